// File: doc/BRIEF.md
# DMA Instruction Override Counter

This block holds a short-lived override mode for the DMA-related instructions of a small controller core. A set command writes an 8-bit configuration: the low five bits give how many of the following DMA instructions the override covers, and the top three bits choose how those instructions are redirected. While the count is nonzero, the block drives redirect controls to the DMA issue logic. These controls choose between a crypto register and the crypto stream, turn on an external-memory override and pick the internal memory. Each DMA wait, DMA store or DMA load that is issued uses up one count. When the count reaches zero the override switches itself off.

A count of all ones is a sticky code: the override then stays in force until the next set command replaces it. When all three type bits are zero and a DMA store is issued under the override, the block tells the issue logic to read the store's length operand as a crypto register index, and it presents that index. The DMA engine is outside this block.

Top module: `dma_ovr_ctrl`

## Requirements
- R1: After reset the configuration readback is 0, `ovr_active` is 0 and every redirect output (`tgt_reg`, `tgt_stream`, `ext_ovr`, `imem_sel`, `len_as_idx`) is 0, with `reg_idx` at 0.
- R2: A set command (`set_vld`=1) loads `set_cfg[7:0]` into the register on the next clock: count = bits 4..0, type = bits 7..5. Bits 31..8 of `set_cfg` are ignored, and `cfg_q[31:8]` always reads 0.
- R3: When the count is neither 0 nor 31 and no set command is present, an issued instruction (`dma_vld`=1) of kind wait (1), store (2) or load (3) lowers the count by one on the next clock. Kind 0 (other) and cycles with `dma_vld`=0 leave the count unchanged.
- R4: A count of 31 (0x1F) is never decremented. It changes only through a set command.
- R5: `ovr_active` is 1 exactly when the count is nonzero. While it is 0, every redirect output is 0, whatever the stored type bits are.
- R6: While active, type bit 5 picks the crypto target: with 0, `tgt_reg`=1 and `tgt_stream`=0; with 1, `tgt_stream`=1 and `tgt_reg`=0.
- R7: While active, `ext_ovr` equals type bit 6 (1 = external-memory override enabled).
- R8: While active, `imem_sel` equals type bit 7 (0 = data memory, 1 = instruction memory).
- R9: `len_as_idx` is 1 only while active, with type bits 7..5 all zero, in a cycle with `dma_vld`=1 and kind store (2). In that case `reg_idx` = `dma_len[3:0]`; in every other cycle `reg_idx` is 0.
- R10: A set command issued while an override is active replaces both count and type on the next clock. No old count carries over.
- R11: When a set command and a counting instruction fall in the same cycle, the register takes the set value exactly and the instruction does not decrement it. The redirect outputs in that cycle follow the configuration held before the set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_vld | input | 1 | Set command strobe |
| set_cfg | input | 32 | Set command data; only bits 7..0 are used |
| dma_vld | input | 1 | An instruction is issued this cycle |
| dma_kind | input | 2 | Instruction kind: 0 other, 1 wait, 2 store, 3 load |
| dma_len | input | 16 | Length operand of the issued instruction |
| cfg_q | output | 32 | Live configuration readback: type and remaining count |
| ovr_active | output | 1 | Override is in force |
| tgt_reg | output | 1 | Redirect target is a crypto register |
| tgt_stream | output | 1 | Redirect target is the crypto stream |
| ext_ovr | output | 1 | External-memory override enabled |
| imem_sel | output | 1 | Internal memory is instruction memory |
| len_as_idx | output | 1 | Current store length is to be read as a register index |
| reg_idx | output | 4 | Crypto register index taken from the length operand |

## Verification
The hardest case to reach from the ports is the collision of a set command with a counting instruction in the same cycle. It matters most when the register holds a live finite count and when it holds the sticky all-ones code, because an ordering mistake appears only as an off-by-one count on the following clock. The stimulus first brings the register to a known live count and then drives both strobes together. It does this once while an override is running and once against the sticky code, and it reads the count back on the next cycle. A second hard case is a stored type with a zero count, which must keep every redirect quiet. It is reached by a set command whose type bits are nonzero and whose count bits are zero.

// File: rtl/dovr_pkg.sv
package dovr_pkg;

  // Instruction kind presented with dma_vld.
  typedef enum logic [1:0] {
    K_OTHER = 2'd0,
    K_WAIT  = 2'd1,
    K_STORE = 2'd2,
    K_LOAD  = 2'd3
  } dma_kind_e;

  // Redirect type flags, MSB first as they sit in the configuration byte.
  typedef struct packed {
    logic imem;    // internal memory select
    logic ext;     // external-memory override
    logic stream;  // crypto stream (1) or crypto register (0)
  } ovr_type_t;

  localparam int TYPE_W = $bits(ovr_type_t);

endpackage

// File: rtl/dovr_counter.sv
module dovr_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [CNT_W-1:0] set_cnt,
  input  logic             step_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic             active
);

  localparam logic [CNT_W-1:0] CNT_INF  = '1;
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             finite_live;

  assign finite_live = (cnt_q != CNT_ZERO) && (cnt_q != CNT_INF);

  // Next state: a set command has priority over a counting step.
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (set_en) begin
      cnt_d  = set_cnt;
      cnt_en = 1'b1;
    end else if (step_en && finite_live) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_ZERO;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign active = (cnt_q != CNT_ZERO);

  // R3: a counting step on a live finite count lowers it by one.
  p_step_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && step_en && cnt_q != CNT_ZERO && cnt_q != CNT_INF)
      |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R4: the sticky code survives any step without a set command.
  p_inf_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && cnt_q == CNT_INF) |=> (cnt_q == CNT_INF));

  // R11: a set command wins over a step in the same cycle.
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (cnt_q == $past(set_cnt)));

  // R3: with no set and no step the count holds.
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !step_en) |=> $stable(cnt_q));

endmodule

// File: rtl/dovr_type_reg.sv
module dovr_type_reg
  import dovr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      set_en,
  input  ovr_type_t set_type,
  output ovr_type_t type_q
);

  ovr_type_t type_d;

  always_comb begin
    type_d = type_q;
    if (set_en) type_d = set_type;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
    end else if (set_en) begin
      type_q <= type_d;
    end
  end

  // R10: a set command replaces the type on the next clock.
  p_type_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (type_q == $past(set_type)));

  // R2: without a set command the type never moves.
  p_type_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !set_en |=> $stable(type_q));

endmodule

// File: rtl/dovr_decode.sv
module dovr_decode
  import dovr_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  ovr_type_t        type_q,
  input  logic             dma_vld,
  input  dma_kind_e        dma_kind,
  input  logic [LEN_W-1:0] dma_len,
  output logic             tgt_reg,
  output logic             tgt_stream,
  output logic             ext_ovr,
  output logic             imem_sel,
  output logic             len_as_idx,
  output logic [IDX_W-1:0] reg_idx
);

  logic type_zero;
  logic store_now;
  logic unused_len_hi;

  assign type_zero = (type_q == '0);
  assign store_now = dma_vld && (dma_kind == K_STORE);

  always_comb begin
    tgt_reg    = active && !type_q.stream;
    tgt_stream = active &&  type_q.stream;
    ext_ovr    = active &&  type_q.ext;
    imem_sel   = active &&  type_q.imem;
    len_as_idx = active && type_zero && store_now;
    reg_idx    = len_as_idx ? dma_len[IDX_W-1:0] : '0;
  end

  assign unused_len_hi = ^dma_len[LEN_W-1:IDX_W];

  // R5: an expired override drives nothing.
  p_quiet_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !(tgt_reg || tgt_stream || ext_ovr || imem_sel || len_as_idx));

  // R6: exactly one crypto target while the override is live.
  p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> $onehot({tgt_reg, tgt_stream}));

  // R9: index reinterpretation only happens on an issued store.
  p_idx_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
    len_as_idx |-> (dma_vld && dma_kind == K_STORE && tgt_reg));

  // R9: the index is zero outside reinterpretation.
  p_idx_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !len_as_idx |-> (reg_idx == '0));

endmodule

// File: rtl/dma_ovr_ctrl.sv
module dma_ovr_ctrl
  import dovr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5,
  parameter int LEN_W  = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_vld,
  input  logic [DATA_W-1:0] set_cfg,
  input  logic              dma_vld,
  input  logic [1:0]        dma_kind,
  input  logic [LEN_W-1:0]  dma_len,
  output logic [DATA_W-1:0] cfg_q,
  output logic              ovr_active,
  output logic              tgt_reg,
  output logic              tgt_stream,
  output logic              ext_ovr,
  output logic              imem_sel,
  output logic              len_as_idx,
  output logic [IDX_W-1:0]  reg_idx
);

  localparam int CFG_W = CNT_W + TYPE_W;

  logic [CNT_W-1:0] cnt_q;
  ovr_type_t        type_q;
  ovr_type_t        set_type;
  dma_kind_e        kind;
  logic             step_en;
  logic             unused_cfg_hi;

  assign kind     = dma_kind_e'(dma_kind);
  assign step_en  = dma_vld && (kind != K_OTHER);
  assign set_type = ovr_type_t'(set_cfg[CFG_W-1:CNT_W]);
  assign unused_cfg_hi = ^set_cfg[DATA_W-1:CFG_W];

  dovr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (set_vld),
    .set_cnt (set_cfg[CNT_W-1:0]),
    .step_en (step_en),
    .cnt_q   (cnt_q),
    .active  (ovr_active)
  );

  dovr_type_reg u_type (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (set_vld),
    .set_type (set_type),
    .type_q   (type_q)
  );

  dovr_decode #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (ovr_active),
    .type_q     (type_q),
    .dma_vld    (dma_vld),
    .dma_kind   (kind),
    .dma_len    (dma_len),
    .tgt_reg    (tgt_reg),
    .tgt_stream (tgt_stream),
    .ext_ovr    (ext_ovr),
    .imem_sel   (imem_sel),
    .len_as_idx (len_as_idx),
    .reg_idx    (reg_idx)
  );

  assign cfg_q = {{(DATA_W-CFG_W){1'b0}}, type_q, cnt_q};

  // R2: the upper readback bits stay zero.
  p_hi_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[DATA_W-1:CFG_W] == '0);

  // R5: active flag tracks a nonzero count.
  p_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_active == (cfg_q[CNT_W-1:0] != '0));

endmodule

// File: tb/dma_ovr_ctrl_tb.sv
module dma_ovr_ctrl_tb;

  logic        clk;
  logic        rst_n;
  logic        set_vld;
  logic [31:0] set_cfg;
  logic        dma_vld;
  logic [1:0]  dma_kind;
  logic [15:0] dma_len;
  logic [31:0] cfg_q;
  logic        ovr_active, tgt_reg, tgt_stream, ext_ovr, imem_sel, len_as_idx;
  logic [3:0]  reg_idx;

  int n_run  = 0;
  int n_fail = 0;
  int m_cnt  = 0;
  int m_type = 0;
  string cur_req = "R1";
  bit done = 0;

  dma_ovr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .set_vld(set_vld), .set_cfg(set_cfg),
    .dma_vld(dma_vld), .dma_kind(dma_kind), .dma_len(dma_len),
    .cfg_q(cfg_q), .ovr_active(ovr_active), .tgt_reg(tgt_reg),
    .tgt_stream(tgt_stream), .ext_ovr(ext_ovr), .imem_sel(imem_sel),
    .len_as_idx(len_as_idx), .reg_idx(reg_idx)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string what, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  // Compare every output with the behavioural model for the current inputs.
  task automatic compare();
    bit act_e, idx_e;
    act_e = (m_cnt != 0);
    idx_e = act_e && (m_type == 0) && dma_vld && (dma_kind == 2'd2);
    chk("cfg_q",      cfg_q, (m_type << 5) | m_cnt);
    chk("ovr_active", ovr_active, act_e);
    chk("tgt_reg",    tgt_reg,    act_e && !m_type[0]);
    chk("tgt_stream", tgt_stream, act_e &&  m_type[0]);
    chk("ext_ovr",    ext_ovr,    act_e &&  m_type[1]);
    chk("imem_sel",   imem_sel,   act_e &&  m_type[2]);
    chk("len_as_idx", len_as_idx, idx_e);
    chk("reg_idx",    reg_idx,    idx_e ? (dma_len & 16'hF) : 0);
  endtask

  // One cycle: drive after the falling edge, check, advance the model, clock.
  task automatic cyc(bit s, logic [31:0] c, bit v, logic [1:0] k, logic [15:0] l);
    @(negedge clk);
    set_vld = s; set_cfg = c; dma_vld = v; dma_kind = k; dma_len = l;
    #1;
    compare();
    if (s) begin
      m_cnt  = c[4:0];
      m_type = c[7:5];
    end else if (v && k != 2'd0 && m_cnt != 0 && m_cnt != 31) begin
      m_cnt = m_cnt - 1;
    end
    @(posedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; set_vld = 0; set_cfg = 0; dma_vld = 0; dma_kind = 0; dma_len = 0;
    #23;
    cur_req = "R1";  // reset state
    compare();
    rst_n = 1'b1;
    cyc(0, 0, 1, 2'd3, 16'h0);

    cur_req = "R2";  // load type 0 count 3, upper bits garbage
    cyc(1, 32'hABCD_1203, 0, 0, 0);
    cur_req = "R9";  // store under type 0 -> index 7
    cyc(0, 0, 1, 2'd2, 16'h05A7);
    cur_req = "R3";  // other kind and idle do not count
    cyc(0, 0, 1, 2'd0, 16'h0003);
    cyc(0, 0, 0, 2'd3, 16'h0);
    cyc(0, 0, 1, 2'd1, 16'h0);
    cur_req = "R5";  // last load expires override
    cyc(0, 0, 1, 2'd3, 16'h0);
    cyc(0, 0, 1, 2'd2, 16'h000C);
    cyc(0, 0, 1, 2'd3, 16'h0);

    cur_req = "R4";  // sticky code with every type bit set
    cyc(1, 32'h0000_00FF, 0, 0, 0);
    for (int i = 0; i < 40; i++) cyc(0, 0, 1, 2'(1 + i % 3), 16'(i));
    cur_req = "R8";
    cyc(0, 0, 0, 0, 0);

    cur_req = "R10"; // replace during active override
    cyc(1, 32'h0000_0042, 1, 2'd1, 0);
    cur_req = "R6";
    cyc(0, 0, 1, 2'd2, 16'h0009);
    cur_req = "R7";
    cyc(1, 32'h0000_0045, 0, 0, 0);
    cyc(0, 0, 1, 2'd3, 0);

    cur_req = "R11"; // set and counting step in the same cycle
    cyc(1, 32'h0000_0004, 1, 2'd2, 16'h0001);
    cyc(0, 0, 0, 0, 0);
    cyc(1, 32'h0000_001F, 0, 0, 0);
    cyc(1, 32'h0000_0002, 1, 2'd3, 0);
    cyc(0, 0, 1, 2'd2, 16'h000E);
    cyc(0, 0, 1, 2'd2, 16'h000E);

    cur_req = "R5";  // stored type with zero count stays quiet
    cyc(1, 32'h0000_00E0, 0, 0, 0);
    cyc(0, 0, 1, 2'd2, 16'h0003);
    cyc(0, 0, 0, 0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule